// File: doc/BRIEF.md
# Three-Phase Gate-Drive Interlock Controller

This block is the clocked decision logic in front of a three-phase half-bridge gate driver. Each phase has an upper and a lower switch. Software or a PWM engine drives one pair of commands per phase. The upper command is active-low and the lower command is active-high. The block turns these commands into six gate-enable outputs. The lower command of a phase has priority over its upper command. An output turns off at once, but it turns on only after a programmable dead-time count, so the two switches of a leg are never closed together. A bypass mode removes the interlock and lets each output follow its own command.

A global disable input and an undervoltage flag each force all six outputs off. Either one overrides every other input. When both are released, or when reset ends, a release sequence runs. The lower outputs first get a refresh pulse of programmable length, which recharges the floating upper supplies. The upper outputs stay blocked until a longer, separately programmed enable interval has elapsed. The dead-time count and both sequence intervals are counts of clock cycles, taken from input ports. Every pin is a plain control level; there is no streaming interface.

Top module: `tri_bridge_gate_ctrl`

## Requirements
- R1: While reset is asserted, all six outputs are 0. Once reset is released, the block runs the same release sequence as after a disable (R9, R10).
- R2: In normal operation, an upper command of 0 requests that phase's upper output on, and a 1 requests it off.
- R3: With the interlock active (bypass 0), a lower command of 1 turns the lower output on and holds the upper output of that phase at 0, whatever the upper command.
- R4: With the interlock active, a lower command of 0 together with an upper command of 1 leaves both outputs of that phase at 0.
- R5: An output whose request goes from off to on rises exactly dead_cnt+1 rising edges after the first edge that samples the request (dead_cnt 0 gives one edge). An output whose request drops is 0 after the first edge that samples the drop.
- R6: If bypass was 0 at the previous edge, the upper and lower outputs of a phase are never both 1.
- R7: With bypass 1, each output follows its own command after one edge with no dead time, and upper and lower may be 1 together.
- R8: If dis or uv is 1 at an edge, all outputs are 0 after that edge. They stay 0 for as long as either input is held, regardless of the other inputs.
- R9: Take the first edge that samples dis, uv and reset all inactive as edge zero. With dead_cnt 0, every lower output is then 1 for exactly refresh_cnt cycles, starting after edge one, whatever lo_cmd is. The upper outputs are 0 during this time.
- R10: After release, no upper output is 1 before enable_cnt+1 edges following edge zero. With dead_cnt 0 and upper requested, the upper output is first 1 after edge enable_cnt+1, assuming enable_cnt is at least refresh_cnt.
- R11: If every upper command is held at 0 and bypass is 0, each lower output follows lo_cmd and each upper output follows its inverse once the dead time has passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| dis | input | 1 | Global disable, active high |
| uv | input | 1 | Undervoltage flag, active high |
| bypass | input | 1 | 1 removes the dead time and the lower-over-upper priority |
| dead_cnt | input | 12 | Turn-on delay, in cycles |
| refresh_cnt | input | 12 | Length of the lower refresh pulse after release, in cycles |
| enable_cnt | input | 12 | Cycles from release until the uppers may switch |
| hi_cmd_n | input | 3 | Upper commands, one per phase, active low |
| lo_cmd | input | 3 | Lower commands, one per phase, active high |
| hi_out | output | 3 | Upper gate enables |
| lo_out | output | 3 | Lower gate enables |

## Verification
The hardest condition to reach from the ports is a change of request that arrives while a turn-on count is still running. This includes a lower command rising during an upper's dead time, bypass being dropped while both outputs are on, and a disable landing partway through the refresh or enable interval. Directed cases pin down the exact edge counts of the dead time and of the release sequence. Seeded random stimulus then toggles the commands every few cycles, with dead times longer than the toggle spacing and with short disable pulses, so interrupted counts occur often. A cycle model in the bench follows every one of these cases.

// File: rtl/gdrv_pkg.sv
package gdrv_pkg;
  // Release-sequence phase seen by the per-leg request logic
  typedef enum logic [1:0] {
    SEQ_HALT    = 2'd0,  // everything forced off
    SEQ_REFRESH = 2'd1,  // lowers forced on, uppers blocked
    SEQ_WAIT    = 2'd2,  // lowers follow commands, uppers blocked
    SEQ_RUN     = 2'd3   // normal operation
  } seq_phase_e;
endpackage

// File: rtl/gdrv_release_seq.sv
module gdrv_release_seq
  import gdrv_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          halt,
  input  logic [CW-1:0] refresh_cnt,
  input  logic [CW-1:0] enable_cnt,
  output seq_phase_e    phase
);
  localparam logic [CW-1:0] T_MAX = {CW{1'b1}};

  logic          run_q;
  logic [CW-1:0] t_q;

  // cycles elapsed since the first edge that saw the halt released
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      t_q   <= '0;
    end else if (halt) begin
      run_q <= 1'b0;
      t_q   <= '0;
    end else begin
      run_q <= 1'b1;
      if (run_q && (t_q != T_MAX)) t_q <= t_q + 1'b1;
    end
  end

  always_comb begin
    if (!run_q || halt)         phase = SEQ_HALT;
    else if (t_q < refresh_cnt) phase = SEQ_REFRESH;
    else if (t_q < enable_cnt)  phase = SEQ_WAIT;
    else                        phase = SEQ_RUN;
  end

  AST_SEQ_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> (t_q == '0 && !run_q)); // R9
endmodule

// File: rtl/gdrv_leg_arb.sv
module gdrv_leg_arb
  import gdrv_pkg::*;
(
  input  seq_phase_e phase,
  input  logic       bypass,
  input  logic       up_cmd_n,
  input  logic       dn_cmd,
  output logic       up_req,
  output logic       dn_req
);
  always_comb begin
    unique case (phase)
      SEQ_HALT: begin
        up_req = 1'b0;
        dn_req = 1'b0;
      end
      SEQ_REFRESH: begin
        up_req = 1'b0;
        dn_req = 1'b1;
      end
      SEQ_WAIT: begin
        up_req = 1'b0;
        dn_req = dn_cmd;
      end
      default: begin
        dn_req = dn_cmd;
        // lower wins unless the interlock is bypassed
        up_req = !up_cmd_n && (bypass || !dn_cmd);
      end
    endcase
  end
endmodule

// File: rtl/gdrv_turnon_delay.sv
module gdrv_turnon_delay #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          bypass,
  input  logic [CW-1:0] dead,
  output logic          gate
);
  logic [CW-1:0] cnt_q;
  logic          gate_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      gate_q <= 1'b0;
    end else if (!req) begin
      // turn-off is never delayed
      cnt_q  <= '0;
      gate_q <= 1'b0;
    end else if (bypass || gate_q) begin
      gate_q <= 1'b1;
    end else if (cnt_q >= dead) begin
      gate_q <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign gate = gate_q;

  AST_RISE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_q) |-> $past(req)); // R5
  AST_FALL_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_q && !req) |=> !gate_q); // R5
endmodule

// File: rtl/tri_bridge_gate_ctrl.sv
module tri_bridge_gate_ctrl
  import gdrv_pkg::*;
#(
  parameter int NPH = 3,
  parameter int CW  = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           dis,
  input  logic           uv,
  input  logic           bypass,
  input  logic [CW-1:0]  dead_cnt,
  input  logic [CW-1:0]  refresh_cnt,
  input  logic [CW-1:0]  enable_cnt,
  input  logic [NPH-1:0] hi_cmd_n,
  input  logic [NPH-1:0] lo_cmd,
  output logic [NPH-1:0] hi_out,
  output logic [NPH-1:0] lo_out
);
  logic       halt;
  seq_phase_e seq_phase;

  assign halt = dis | uv;

  gdrv_release_seq #(.CW(CW)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .halt        (halt),
    .refresh_cnt (refresh_cnt),
    .enable_cnt  (enable_cnt),
    .phase       (seq_phase)
  );

  for (genvar p = 0; p < NPH; p++) begin : g_leg
    logic up_req, dn_req;

    gdrv_leg_arb u_arb (
      .phase    (seq_phase),
      .bypass   (bypass),
      .up_cmd_n (hi_cmd_n[p]),
      .dn_cmd   (lo_cmd[p]),
      .up_req   (up_req),
      .dn_req   (dn_req)
    );

    gdrv_turnon_delay #(.CW(CW)) u_up (
      .clk (clk), .rst_n (rst_n), .req (up_req),
      .bypass (bypass), .dead (dead_cnt), .gate (hi_out[p])
    );

    gdrv_turnon_delay #(.CW(CW)) u_dn (
      .clk (clk), .rst_n (rst_n), .req (dn_req),
      .bypass (bypass), .dead (dead_cnt), .gate (lo_out[p])
    );
  end

  AST_NO_SHOOT: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bypass) |-> ((hi_out & lo_out) == '0)); // R6
  AST_HALT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> (hi_out == '0 && lo_out == '0)); // R8
  AST_REFRESH_UPPERS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_phase == SEQ_REFRESH) |=> (hi_out == '0)); // R9
  AST_UPPER_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_phase != SEQ_RUN) |=> (hi_out == '0)); // R10
  AST_RESET_OFF: assert property (@(posedge clk)
    !rst_n |-> (hi_out == '0 && lo_out == '0)); // R1
endmodule

// File: tb/tri_bridge_gate_ctrl_bench.sv
module tri_bridge_gate_ctrl_bench;
  localparam int NPH = 3;
  localparam int CW  = 12;
  localparam int LIMIT = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dis = 1'b0, uv = 1'b0, bypass = 1'b0;
  logic [CW-1:0] dead_cnt = '0, refresh_cnt = 12'd6, enable_cnt = 12'd10;
  logic [NPH-1:0] hi_cmd_n = '1, lo_cmd = '0;
  logic [NPH-1:0] hi_out, lo_out;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int unsigned seed_val;

  always #10 clk = ~clk;

  tri_bridge_gate_ctrl #(.NPH(NPH), .CW(CW)) u_tri_bridge_gate_ctrl (
    .clk (clk), .rst_n (rst_n), .dis (dis), .uv (uv), .bypass (bypass),
    .dead_cnt (dead_cnt), .refresh_cnt (refresh_cnt), .enable_cnt (enable_cnt),
    .hi_cmd_n (hi_cmd_n), .lo_cmd (lo_cmd), .hi_out (hi_out), .lo_out (lo_out)
  );

  // ---------------- cycle model built from the requirements ----------------
  logic          m_run;
  logic [CW-1:0] m_t;
  logic [CW-1:0] m_cnt [6];
  logic [5:0]    m_out;       // [2:0] uppers, [5:3] lowers
  logic          m_byp_prev;

  function automatic logic [1:0] f_phase(input logic run, input logic [CW-1:0] t,
                                         input logic halt, input logic [CW-1:0] rf,
                                         input logic [CW-1:0] en);
    if (!run || halt) return 2'd0;
    if (t < rf)       return 2'd1;
    if (t < en)       return 2'd2;
    return 2'd3;
  endfunction

  function automatic logic f_req(input logic [1:0] ph, input int o, input logic byp,
                                 input logic [NPH-1:0] hn, input logic [NPH-1:0] lc);
    int leg;
    leg = (o < 3) ? o : o - 3;
    case (ph)
      2'd0: return 1'b0;
      2'd1: return (o >= 3);
      2'd2: return (o >= 3) ? lc[leg] : 1'b0;
      default: return (o >= 3) ? lc[leg] : (!hn[leg] && (byp || !lc[leg]));
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run <= 1'b0; m_t <= '0; m_out <= '0; m_byp_prev <= 1'b0;
      for (int o = 0; o < 6; o++) m_cnt[o] <= '0;
    end else begin
      logic [1:0] ph;
      ph = f_phase(m_run, m_t, dis | uv, refresh_cnt, enable_cnt);
      m_byp_prev <= bypass;
      if (dis | uv) begin m_run <= 1'b0; m_t <= '0; end
      else begin
        m_run <= 1'b1;
        if (m_run && m_t != {CW{1'b1}}) m_t <= m_t + 1'b1;
      end
      for (int o = 0; o < 6; o++) begin
        if (!f_req(ph, o, bypass, hi_cmd_n, lo_cmd)) begin
          m_cnt[o] <= '0; m_out[o] <= 1'b0;
        end else if (bypass || m_out[o]) m_out[o] <= 1'b1;
        else if (m_cnt[o] >= dead_cnt) m_out[o] <= 1'b1;
        else m_cnt[o] <= m_cnt[o] + 1'b1;
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // every cycle: ports against the model, plus the shoot-through rule
  always @(posedge clk) begin
    #5;
    cyc++;
    if (rst_n) begin
      check("R2 R3 R4 R5 R7 R8 R9 R10 model", {26'd0, lo_out, hi_out}, {26'd0, m_out});
      if (!m_byp_prev) check("R6 no shoot-through", {29'd0, hi_out & lo_out}, 32'd0);
    end
    if (cyc > LIMIT) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, LIMIT);
      finish_run();
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic sample(); @(posedge clk); #5; endtask
  task automatic idle(input int n); for (int i = 0; i < n; i++) @(negedge clk); endtask

  initial begin
    int k, cnt_on, first;
    seed_val = $urandom(32'd7321);

    // R1: reset state
    dead_cnt = 0; refresh_cnt = 6; enable_cnt = 10;
    idle(3);
    check("R1 reset outputs", {26'd0, lo_out, hi_out}, 32'd0);

    // R1 R9: refresh after reset release, lowers on for refresh_cnt cycles
    @(negedge clk); rst_n = 1'b1;
    cnt_on = 0;
    for (int i = 0; i < 30; i++) begin
      sample();
      if (lo_out == 3'b111) cnt_on++;
      if (hi_out != 0) check("R9 uppers off in refresh", {29'd0, hi_out}, 32'd0);
    end
    check("R1 R9 refresh length", cnt_on, 6);

    // R10: upper enable delay from release
    @(negedge clk); dis = 1'b1; hi_cmd_n = '0; lo_cmd = '0;
    refresh_cnt = 4; enable_cnt = 9;
    idle(3);
    dis = 1'b0;
    first = 0;
    for (k = 1; k <= 40; k++) begin
      sample();
      if (first == 0 && hi_out == 3'b111) first = k;
    end
    check("R10 first upper sample", first, 11);

    // R5 R2: exact dead time on a lower and an upper
    @(negedge clk); hi_cmd_n = '1; lo_cmd = '0; dead_cnt = 7;
    idle(12);
    lo_cmd[0] = 1'b1; hi_cmd_n[1] = 1'b0;
    first = 0;
    for (k = 1; k <= 20; k++) begin
      sample();
      if (first == 0 && lo_out[0]) first = k;
      if (k == 8) check("R2 upper on from low command", {31'd0, hi_out[1]}, 32'd1);
    end
    check("R5 dead time lower rise", first, 8);
    @(negedge clk); lo_cmd[0] = 1'b0;
    sample();
    check("R5 immediate turn-off", {31'd0, lo_out[0]}, 32'd0);

    // R3 R4: lower priority, both off
    @(negedge clk); dead_cnt = 2; hi_cmd_n = '1; lo_cmd = '0;
    hi_cmd_n[2] = 1'b0; lo_cmd[2] = 1'b1;
    idle(6);
    check("R3 lower wins", {30'd0, hi_out[2], lo_out[2]}, 32'b01);
    lo_cmd[2] = 1'b0; hi_cmd_n[2] = 1'b1;
    idle(6);
    check("R4 both off", {30'd0, hi_out[2], lo_out[2]}, 32'b00);

    // R11: complementary drive with uppers tied on
    hi_cmd_n = '0; dead_cnt = 3; lo_cmd = 3'b101;
    idle(8);
    check("R11 pattern A", {26'd0, lo_out, hi_out}, {26'd0, 3'b101, 3'b010});
    lo_cmd = 3'b010;
    idle(8);
    check("R11 pattern B", {26'd0, lo_out, hi_out}, {26'd0, 3'b010, 3'b101});

    // R7: bypass lets both on after one edge
    @(negedge clk); bypass = 1'b1; lo_cmd = 3'b111; hi_cmd_n = 3'b000;
    sample();
    check("R7 bypass both on", {26'd0, lo_out, hi_out}, {26'd0, 3'b111, 3'b111});
    @(negedge clk); bypass = 1'b0;
    sample();
    check("R7 R3 interlock back", {26'd0, lo_out, hi_out}, {26'd0, 3'b111, 3'b000});

    // R8: disable and undervoltage override
    @(negedge clk); lo_cmd = 3'b010; dead_cnt = 0; idle(3);
    dis = 1'b1;
    sample();
    check("R8 dis forces off", {26'd0, lo_out, hi_out}, 32'd0);
    @(negedge clk); bypass = 1'b1; lo_cmd = '1;
    idle(4);
    check("R8 dis held overrides", {26'd0, lo_out, hi_out}, 32'd0);
    bypass = 1'b0; dis = 1'b0; lo_cmd = 3'b001;
    idle(20);
    uv = 1'b1;
    sample();
    check("R8 uv forces off", {26'd0, lo_out, hi_out}, 32'd0);
    @(negedge clk); uv = 1'b0;

    // random phase, model-checked every cycle
    refresh_cnt = 5; enable_cnt = 12;
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      if ($urandom_range(3) == 0) lo_cmd[$urandom_range(2)] ^= 1'b1;
      if ($urandom_range(3) == 0) hi_cmd_n[$urandom_range(2)] ^= 1'b1;
      if ($urandom_range(40) == 0) dead_cnt = 12'($urandom_range(9));
      if ($urandom_range(300) == 0) bypass = ~bypass;
      if ($urandom_range(250) == 0) dis = 1'b1;
      else if (dis && $urandom_range(4) == 0) dis = 1'b0;
      if ($urandom_range(400) == 0) uv = 1'b1;
      else if (uv && $urandom_range(3) == 0) uv = 1'b0;
      if (dis && $urandom_range(2) == 0) begin
        refresh_cnt = 12'($urandom_range(8));
        enable_cnt  = refresh_cnt + 12'($urandom_range(10));
      end
    end
    @(negedge clk); dis = 1'b0; uv = 1'b0;
    idle(30);
    finish_run();
  end
endmodule